// File: doc/BRIEF.md
# Bidirectional Port with Change Interrupt

An eight-bit general purpose I/O port as seen from a register bus. Each bit has a direction flop and an output latch. A direction bit of 1 makes the pin an input, so its driver is off. A direction bit of 0 drives the latch value onto the pad. A port read returns the synchronized pin levels, not the latch. A port write loads the latch.

The upper nibble carries a change detector. The detector remembers the upper pin levels seen at the most recent port access, which is either a read or a write. It raises a sticky change flag whenever an input-configured upper pin differs from that snapshot. Bit 0 also feeds an edge detector with a selectable polarity, which sets its own external interrupt flag. A single active-low enable turns on weak pull-ups, and only pins configured as inputs receive them. An interrupt controller outside this block consumes the two flags.

Top module: `gpio_port_ioc`

## Requirements
- R1: On reset, every direction bit is 1 (input), the output latch is 0x00, both flags are 0, pad_oe_o is 0x00 and pad_pu_o is 0x00.
- R2: A cycle with dir_wr_i loads wdata_i into the direction register. After that edge, pad_oe_o equals the bitwise inverse of the direction register, and a dir_rd_i access returns the direction register on rdata_o.
- R3: A cycle with port_wr_i loads wdata_i into the output latch, which appears on pad_out_o after that edge. A port_rd_i access returns the synchronized pin levels on rdata_o, not the latch. A pin change becomes visible on rdata_o two clock edges after it occurs.
- R4: chg_flag_o is set when any pin among bits 7:4 that is configured as an input differs from the snapshot. Pins on bits 3:0 never set chg_flag_o.
- R5: An upper pin whose direction bit is 0 (output) never contributes to chg_flag_o.
- R6: While a mismatch persists, chg_flag_o stays set even when chg_clr_i is pulsed. A port read or a port write retakes the snapshot from the current pins. After that, a chg_clr_i pulse clears the flag.
- R7: pad_pu_o[i] is 1 exactly when pull_en_ni is 0 and direction bit i is 1.
- R8: When edge_rise_i is 1, only a 0-to-1 transition on pin 0 sets ext_flag_o. When edge_rise_i is 0, only a 1-to-0 transition sets it.
- R9: ext_clr_i clears ext_flag_o. If a qualifying edge and ext_clr_i fall in the same cycle, the flag is set. The same set-over-clear priority applies to chg_flag_o and chg_clr_i.
- R10: A pin change sets its flag on the third rising clock edge after it is applied. The first two edges belong to the two-flop synchronizer.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wdata_i | input | 8 | Bus write data |
| port_wr_i | input | 1 | Write output latch |
| port_rd_i | input | 1 | Read pin levels |
| dir_wr_i | input | 1 | Write direction register |
| dir_rd_i | input | 1 | Read direction register |
| rdata_o | output | 8 | Bus read data, zero when no read strobe is active |
| pull_en_ni | input | 1 | Global weak pull-up enable, active low |
| edge_rise_i | input | 1 | Bit 0 edge select: 1 selects rising, 0 selects falling |
| chg_clr_i | input | 1 | Clear strobe for the change flag |
| ext_clr_i | input | 1 | Clear strobe for the external flag |
| pin_i | input | 8 | Raw pad input levels |
| pad_out_o | output | 8 | Output latch to pad drivers |
| pad_oe_o | output | 8 | Driver enables, 1 means driving |
| pad_pu_o | output | 8 | Weak pull-up enables |
| chg_flag_o | output | 1 | Upper-nibble change flag |
| ext_flag_o | output | 1 | Bit 0 edge flag |

## Verification
Several behaviours are checked by assertions on every cycle:
- The driver enables follow a direction write.
- The output latch follows a port write.
- No pull-up is ever enabled on a driven pin.
- Both flags hold until their clear strobe arrives.

Other behaviours only the bench scenarios can show:
- The snapshot refreshes on each port access.
- Output-configured pins are masked out of change detection.
- The three-edge latency from pin to flag.
- The edge polarity selection.
- Set winning over a clear in the same cycle.

The bench shows these by sweeping every direction mask against every upper-nibble pattern.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned PORT_W  = 8;
  localparam int unsigned CHG_LO  = 4;
  localparam int unsigned SYNC_N  = 2;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg[s] <= '0;
      else if (s == 0) stg[s] <= d_i;
      else stg[s] <= stg[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/gpio_chg_det.sv
module gpio_chg_det #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pin_s_i,
  input  logic [W-1:0] in_mask_i,
  input  logic         snap_i,
  input  logic         clr_i,
  output logic         flag_o
);
  logic [W-1:0] snap_q;
  logic         mismatch;

  assign mismatch = |((pin_s_i ^ snap_q) & in_mask_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) snap_q <= '0;
    else if (snap_i) snap_q <= pin_s_i;
  end

  // set dominates clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_o <= 1'b0;
    else if (mismatch) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/gpio_edge_det.sv
module gpio_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_s_i,
  input  logic rise_i,
  input  logic clr_i,
  output logic flag_o
);
  logic prev_q;
  logic hit;

  assign hit = rise_i ? (pin_s_i & ~prev_q) : (~pin_s_i & prev_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      flag_o <= 1'b0;
    end else begin
      prev_q <= pin_s_i;
      if (hit) flag_o <= 1'b1;
      else if (clr_i) flag_o <= 1'b0;
    end
  end
endmodule

// File: rtl/gpio_port_ioc.sv
module gpio_port_ioc
  import gpio_pkg::*;
#(
  parameter int unsigned W    = PORT_W,
  parameter int unsigned LO   = CHG_LO,
  parameter int unsigned SYNC = SYNC_N
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] wdata_i,
  input  logic         port_wr_i,
  input  logic         port_rd_i,
  input  logic         dir_wr_i,
  input  logic         dir_rd_i,
  output logic [W-1:0] rdata_o,
  input  logic         pull_en_ni,
  input  logic         edge_rise_i,
  input  logic         chg_clr_i,
  input  logic         ext_clr_i,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] pad_out_o,
  output logic [W-1:0] pad_oe_o,
  output logic [W-1:0] pad_pu_o,
  output logic         chg_flag_o,
  output logic         ext_flag_o
);
  localparam int unsigned CW = W - LO;

  logic [W-1:0] dir_q, lat_q, pin_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q <= '1;
      lat_q <= '0;
    end else begin
      if (dir_wr_i)  dir_q <= wdata_i;
      if (port_wr_i) lat_q <= wdata_i;
    end
  end

  gpio_sync #(.W(W), .STAGES(SYNC)) u_sync (
    .clk_i, .rst_ni, .d_i(pin_i), .q_o(pin_s)
  );

  gpio_chg_det #(.W(CW)) u_chg (
    .clk_i, .rst_ni,
    .pin_s_i  (pin_s[W-1:LO]),
    .in_mask_i(dir_q[W-1:LO]),
    .snap_i   (port_rd_i | port_wr_i),
    .clr_i    (chg_clr_i),
    .flag_o   (chg_flag_o)
  );

  gpio_edge_det u_ext (
    .clk_i, .rst_ni,
    .pin_s_i(pin_s[0]),
    .rise_i (edge_rise_i),
    .clr_i  (ext_clr_i),
    .flag_o (ext_flag_o)
  );

  always_comb begin
    if (port_rd_i)     rdata_o = pin_s;
    else if (dir_rd_i) rdata_o = dir_q;
    else               rdata_o = '0;
  end

  assign pad_out_o = lat_q;
  assign pad_oe_o  = ~dir_q;
  assign pad_pu_o  = dir_q & {W{~pull_en_ni}};
endmodule

// File: rtl/gpio_port_ioc_chk.sv
module gpio_port_ioc_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [W-1:0] wdata_i,
  input logic         port_wr_i,
  input logic         dir_wr_i,
  input logic         pull_en_ni,
  input logic         chg_clr_i,
  input logic         ext_clr_i,
  input logic [W-1:0] pad_out_o,
  input logic [W-1:0] pad_oe_o,
  input logic [W-1:0] pad_pu_o,
  input logic         chg_flag_o,
  input logic         ext_flag_o
);
  a_r2_oe_follows_dir: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dir_wr_i |=> pad_oe_o == ~$past(wdata_i));

  a_r3_latch_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    port_wr_i |=> pad_out_o == $past(wdata_i));

  a_r7_no_pu_on_driver: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_pu_o & pad_oe_o) == '0);

  a_r7_pu_off_when_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pull_en_ni |-> pad_pu_o == '0);

  a_r6_chg_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chg_flag_o && !chg_clr_i) |=> chg_flag_o);

  a_r9_ext_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_flag_o && !ext_clr_i) |=> ext_flag_o);
endmodule

bind gpio_port_ioc gpio_port_ioc_chk #(.W(W)) u_chk (
  .clk_i, .rst_ni, .wdata_i, .port_wr_i, .dir_wr_i, .pull_en_ni,
  .chg_clr_i, .ext_clr_i, .pad_out_o, .pad_oe_o, .pad_pu_o,
  .chg_flag_o, .ext_flag_o
);

// File: tb/sim_gpio_port_ioc.sv
`timescale 1ns/1ps
module sim_gpio_port_ioc;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] wdata_i = '0;
  logic       port_wr_i = 0, port_rd_i = 0, dir_wr_i = 0, dir_rd_i = 0;
  logic [7:0] rdata_o;
  logic       pull_en_ni = 1'b1, edge_rise_i = 1'b1;
  logic       chg_clr_i = 0, ext_clr_i = 0;
  logic [7:0] pin_i = '0;
  logic [7:0] pad_out_o, pad_oe_o, pad_pu_o;
  logic       chg_flag_o, ext_flag_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  gpio_port_ioc u0 (.*);

  task automatic step(int n = 1);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_dir(logic [7:0] v);
    wdata_i = v; dir_wr_i = 1; step(); dir_wr_i = 0;
  endtask

  task automatic wr_port(logic [7:0] v);
    wdata_i = v; port_wr_i = 1; step(); port_wr_i = 0;
  endtask

  task automatic rd_port(output logic [7:0] v);
    port_rd_i = 1; #0.5; v = rdata_o; step(); port_rd_i = 0;
  endtask

  task automatic rd_dir(output logic [7:0] v);
    dir_rd_i = 1; #0.5; v = rdata_o; step(); dir_rd_i = 0;
  endtask

  task automatic clr_chg();
    chg_clr_i = 1; step(); chg_clr_i = 0;
  endtask

  task automatic clr_ext();
    ext_clr_i = 1; step(); ext_clr_i = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    step(3);
    rst_ni = 1'b1;
    step();
    // R1
    chk("R1 oe", pad_oe_o, 8'h00);
    chk("R1 out", pad_out_o, 8'h00);
    chk("R1 pu", pad_pu_o, 8'h00);
    chk("R1 flags", {6'b0, chg_flag_o, ext_flag_o}, 8'h00);
    rd_dir(r); chk("R1 dir", r, 8'hFF);

    // R2 R7: exhaustive direction sweep, both pull-up settings
    for (int d = 0; d < 256; d++) begin
      wr_dir(8'(d));
      chk("R2 oe", pad_oe_o, ~8'(d));
      rd_dir(r); chk("R2 dir read", r, 8'(d));
      pull_en_ni = 1'b0; #0.5;
      chk("R7 pu on", pad_pu_o, 8'(d));
      pull_en_ni = 1'b1; #0.5;
      chk("R7 pu off", pad_pu_o, 8'h00);
    end
    wr_dir(8'hFF);

    // R3: latch vs pins, read latency
    for (int v = 0; v < 256; v += 37) begin
      wr_port(8'(v));
      chk("R3 latch", pad_out_o, 8'(v));
    end
    pin_i = 8'h0E;                       // upper nibble quiet, bit0 low
    step();
    rd_port(r); chk("R3 one edge", r, 8'h00);
    rd_port(r); chk("R3 pin read", r, 8'h0E);
    pin_i = 8'h00; step(3);
    rd_port(r);
    clr_chg(); clr_ext();
    chk("R3 quiet", {6'b0, chg_flag_o, ext_flag_o}, 8'h00);

    // R4 R5: every direction mask against every upper pattern
    for (int m = 0; m < 16; m++) begin
      wr_dir({4'(m), 4'hF});
      for (int p = 1; p < 16; p++) begin
        pin_i = {4'(p), 4'h0};
        step(3);
        chk((m == 15) ? "R4 change" : "R5 masked", {7'b0, chg_flag_o},
            {7'b0, |(4'(p) & 4'(m))});
        pin_i = 8'h00; step(3);
        clr_chg();
        chk("R4 cleared", {7'b0, chg_flag_o}, 8'h00);
      end
    end
    wr_dir(8'hFF);

    // R4: lower nibble never sets change flag
    for (int p = 1; p < 16; p++) begin
      pin_i = {4'h0, 4'(p)}; step(3);
      chk("R4 lower ignored", {7'b0, chg_flag_o}, 8'h00);
      pin_i = 8'h00; step(3);
    end
    clr_ext();

    // R10: latency
    pin_i = 8'h20; step(2);
    chk("R10 not yet", {7'b0, chg_flag_o}, 8'h00);
    step();
    chk("R10 third edge", {7'b0, chg_flag_o}, 8'h01);

    // R6: persistence, then read retakes snapshot
    clr_chg();
    chk("R6 persists", {7'b0, chg_flag_o}, 8'h01);
    rd_port(r);
    clr_chg();
    chk("R6 read then clear", {7'b0, chg_flag_o}, 8'h00);
    // R6: write also retakes snapshot
    pin_i = 8'h00; step(3);
    clr_chg();
    chk("R6 persists again", {7'b0, chg_flag_o}, 8'h01);
    wr_port(8'h5A);
    clr_chg();
    chk("R6 write then clear", {7'b0, chg_flag_o}, 8'h00);

    // R8: rising select
    edge_rise_i = 1'b1;
    pin_i[0] = 1'b1; step(3);
    chk("R8 rise sets", {7'b0, ext_flag_o}, 8'h01);
    clr_ext();
    chk("R9 clear", {7'b0, ext_flag_o}, 8'h00);
    pin_i[0] = 1'b0; step(3);
    chk("R8 fall ignored", {7'b0, ext_flag_o}, 8'h00);
    // R8: falling select
    edge_rise_i = 1'b0;
    pin_i[0] = 1'b1; step(3);
    chk("R8 rise ignored", {7'b0, ext_flag_o}, 8'h00);
    pin_i[0] = 1'b0; step(3);
    chk("R8 fall sets", {7'b0, ext_flag_o}, 8'h01);
    clr_ext();

    // R9: set beats clear in same cycle
    pin_i[0] = 1'b1; step(3);
    chk("R9 no fall yet", {7'b0, ext_flag_o}, 8'h00);
    pin_i[0] = 1'b0; step(2);
    ext_clr_i = 1; step(); ext_clr_i = 0;
    chk("R9 set wins", {7'b0, ext_flag_o}, 8'h01);
    pin_i = 8'h80; step(2);
    chg_clr_i = 1; step(); chg_clr_i = 0;
    chk("R9 chg set wins", {7'b0, chg_flag_o}, 8'h01);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule